// File: doc/BRIEF.md
# Message Interrupt Vector Aggregator

This block collects message-signalled interrupts and folds them into one level interrupt for a processor's interrupt controller. Each vector owns one 32-bit word in a vector window. An inbound message write to that word latches the vector as pending. A read of the same word acknowledges it and clears the pending state. The interconnect in front of the block presents the window as a word index, which is the byte offset divided by four. The message data for vector n is n by convention, so decode uses the word index alone.

A second register port holds three registers:
- a status view of the enabled pending vectors, at offset 0x0;
- an error flag, at offset 0x4;
- the enable mask, at offset 0x8.

The service routine reads status, reads the word of each set vector to acknowledge it, and repeats until status reads zero. Vectors that arrive during that loop therefore stay visible. The vector count `NUM_VEC` is a parameter of at most 32. The vector index width `VEC_IW` must be wide enough to address `NUM_VEC` words.

Top module: `msi_irq_aggregator`

## Requirements
- R1: After a synchronous reset, every pending bit, the mask (offset 0x8) and the error register (offset 0x4) are zero, and `irq_out` is low.
- R2: A vector-window write with word index n < NUM_VEC marks vector n pending and leaves every other vector unchanged.
- R3: A vector-window read with word index n clears vector n's pending state, and `vec_rdata` is always zero.
- R4: When a write to vector n and a clearing read of vector n fall in the same cycle, vector n stays pending.
- R5: The mask register at offset 0x8 is read/write, and bit n set to 1 enables vector n to drive the interrupt. Mask bits at or above NUM_VEC cannot be set and read as zero.
- R6: The status register at offset 0x0 reads pending AND mask, with vector n at bit n. Bits at or above NUM_VEC read zero.
- R7: `irq_out` is registered and equals the OR of pending AND mask as it stood one clock earlier. It stays high until every enabled pending vector has been cleared.
- R8: A masked vector stays latched as pending and appears in status and on `irq_out` once its mask bit is set.
- R9: A vector-window write with word index at or above NUM_VEC changes no pending bit and sets error bit 0. Writing 1 to error bit 0 clears it, and writing 0 leaves it. A set and a clear in the same cycle leave it set.
- R10: A register read returns its data on `csr_rdata` one clock after the strobe. Offsets other than 0x0, 0x4 and 0x8 read zero.
- R11: Writing all zeros to the mask disables every vector: `irq_out` falls one clock later while the pending bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_wr_en | input | 1 | Message write strobe on the vector window |
| vec_wr_idx | input | VEC_IW | Word index of the message write |
| vec_rd_en | input | 1 | Acknowledge read strobe on the vector window |
| vec_rd_idx | input | VEC_IW | Word index of the acknowledge read |
| vec_rdata | output | 32 | Vector-window read data, always zero |
| csr_wr_en | input | 1 | Register write strobe |
| csr_rd_en | input | 1 | Register read strobe |
| csr_addr | input | 4 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Registered register read data |
| irq_out | output | 1 | Level interrupt to the processor |

## Verification
Pending and error state update on the rising edge that samples the vector strobe. `irq_out` follows one edge after that, and register read data appears on the edge that samples the read strobe. The bench keeps a behavioural model that applies the same rules on each rising edge. It compares `irq_out`, `csr_rdata` and `vec_rdata` 1 ns after every edge, and it drives stimulus on falling edges. The named checks wait the exact number of falling edges these latencies imply before they sample a result.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned CSR_AW = 4;

  localparam logic [CSR_AW-1:0] OFS_STATUS = 4'h0;
  localparam logic [CSR_AW-1:0] OFS_ERROR  = 4'h4;
  localparam logic [CSR_AW-1:0] OFS_MASK   = 4'h8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ERROR,
    SEL_MASK
  } csr_sel_e;

  function automatic logic [REG_W-1:0] vec_valid_bits(int unsigned nv);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < REG_W; i++) begin
      if (i < nv) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic csr_sel_e decode_csr(logic [CSR_AW-1:0] a);
    case (a)
      OFS_STATUS: return SEL_STATUS;
      OFS_ERROR:  return SEL_ERROR;
      OFS_MASK:   return SEL_MASK;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
  parameter int unsigned NUM_VEC = 24,
  parameter int unsigned VEC_IW  = 6
) (
  input  logic              wr_en,
  input  logic [VEC_IW-1:0] wr_idx,
  input  logic              rd_en,
  input  logic [VEC_IW-1:0] rd_idx,
  output logic [NUM_VEC-1:0] set_vec,
  output logic [NUM_VEC-1:0] clr_vec,
  output logic              bad_wr
);
  localparam int unsigned SPAN = 1 << VEC_IW;

  // One comparator pair per vector; out-of-range indices hit nothing.
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_dec
    assign set_vec[g] = wr_en && (int'(wr_idx) == g);
    assign clr_vec[g] = rd_en && (int'(rd_idx) == g);
  end

  generate
    if (SPAN > NUM_VEC) begin : g_range
      assign bad_wr = wr_en && (int'(wr_idx) >= int'(NUM_VEC));
    end else begin : g_full
      assign bad_wr = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/msi_pending_bank.sv
module msi_pending_bank #(
  parameter int unsigned NUM_VEC = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] set_vec,
  input  logic [NUM_VEC-1:0] clr_vec,
  output logic [NUM_VEC-1:0] pend
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    // Set has priority over the acknowledge read of the same vector.
    always_ff @(posedge clk) begin
      if (rst)             pend[g] <= 1'b0;
      else if (set_vec[g]) pend[g] <= 1'b1;
      else if (clr_vec[g]) pend[g] <= 1'b0;
    end

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (rst)
      set_vec[g] |=> pend[g]); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[g] && !set_vec[g]) |=> !pend[g]); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!clr_vec[g] && !set_vec[g]) |=> $stable(pend[g])); // R8
  end
endmodule

// File: rtl/msi_csr_regs.sv
module msi_csr_regs
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_VEC = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               csr_wr_en,
  input  logic               csr_rd_en,
  input  logic [CSR_AW-1:0]  csr_addr,
  input  logic [REG_W-1:0]   csr_wdata,
  input  logic [NUM_VEC-1:0] pend,
  input  logic               bad_wr,
  output logic [NUM_VEC-1:0] mask_en,
  output logic [REG_W-1:0]   csr_rdata
);
  localparam logic [REG_W-1:0] VALID = vec_valid_bits(NUM_VEC);

  csr_sel_e         sel;
  logic [REG_W-1:0] mask_q;
  logic             err_q;
  logic [REG_W-1:0] status_w;
  logic [REG_W-1:0] rd_mux;

  assign sel     = decode_csr(csr_addr);
  assign mask_en = mask_q[NUM_VEC-1:0];

  always_comb begin
    status_w = '0;
    status_w[NUM_VEC-1:0] = pend & mask_q[NUM_VEC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (csr_wr_en && sel == SEL_MASK) mask_q <= csr_wdata & VALID;
  end

  // A new range error wins over a same-cycle write-one-to-clear.
  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else if (bad_wr) err_q <= 1'b1;
    else if (csr_wr_en && sel == SEL_ERROR && csr_wdata[0]) err_q <= 1'b0;
  end

  always_comb begin
    case (sel)
      SEL_STATUS: rd_mux = status_w;
      SEL_ERROR:  rd_mux = {{(REG_W-1){1'b0}}, err_q};
      SEL_MASK:   rd_mux = mask_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) csr_rdata <= '0;
    else     csr_rdata <= csr_rd_en ? rd_mux : '0;
  end

  AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (rst)
    (csr_rd_en && sel == SEL_STATUS) |=> ((csr_rdata & ~VALID) == '0)); // R6
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> err_q); // R9
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (csr_wr_en && sel == SEL_ERROR && csr_wdata[0] && !bad_wr) |=> !err_q); // R9
  AST_MASK_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    (csr_wr_en && sel == SEL_MASK && csr_wdata == '0) |=> (mask_en == '0)); // R11
endmodule

// File: rtl/msi_irq_aggregator.sv
module msi_irq_aggregator
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_VEC = 24,
  parameter int unsigned VEC_IW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vec_wr_en,
  input  logic [VEC_IW-1:0] vec_wr_idx,
  input  logic              vec_rd_en,
  input  logic [VEC_IW-1:0] vec_rd_idx,
  output logic [31:0]       vec_rdata,
  input  logic              csr_wr_en,
  input  logic              csr_rd_en,
  input  logic [3:0]        csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              irq_out
);
  logic [NUM_VEC-1:0] set_vec;
  logic [NUM_VEC-1:0] clr_vec;
  logic               bad_wr;
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] mask_en;
  logic               irq_q;

  msi_vec_decode #(.NUM_VEC(NUM_VEC), .VEC_IW(VEC_IW)) u_dec (
    .wr_en   (vec_wr_en),
    .wr_idx  (vec_wr_idx),
    .rd_en   (vec_rd_en),
    .rd_idx  (vec_rd_idx),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .bad_wr  (bad_wr)
  );

  msi_pending_bank #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pend    (pend)
  );

  msi_csr_regs #(.NUM_VEC(NUM_VEC)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .csr_wr_en (csr_wr_en),
    .csr_rd_en (csr_rd_en),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .pend      (pend),
    .bad_wr    (bad_wr),
    .mask_en   (mask_en),
    .csr_rdata (csr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend & mask_en);
  end

  assign irq_out   = irq_q;
  assign vec_rdata = '0;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(pend & mask_en)))); // R7
  AST_BAD_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (bad_wr && !vec_rd_en) |=> $stable(pend)); // R9
endmodule

// File: tb/msi_irq_aggregator_test.sv
`timescale 1ns/1ps
module msi_irq_aggregator_test;
  localparam int NV = 24;
  localparam int IW = 6;
  localparam logic [31:0] VM = 32'h00FF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vec_wr_en = 0, vec_rd_en = 0, csr_wr_en = 0, csr_rd_en = 0;
  logic [IW-1:0] vec_wr_idx = '0, vec_rd_idx = '0;
  logic [3:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] vec_rdata, csr_rdata;
  logic irq_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  msi_irq_aggregator #(.NUM_VEC(NV), .VEC_IW(IW)) uut (
    .clk(clk), .rst(rst),
    .vec_wr_en(vec_wr_en), .vec_wr_idx(vec_wr_idx),
    .vec_rd_en(vec_rd_en), .vec_rd_idx(vec_rd_idx), .vec_rdata(vec_rdata),
    .csr_wr_en(csr_wr_en), .csr_rd_en(csr_rd_en), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_out(irq_out)
  );

  // Behavioural reference model, advanced on each rising edge.
  bit [31:0] m_pend, m_mask, m_crd;
  bit        m_err, m_irq;

  always @(posedge clk) begin
    bit [31:0] np;
    if (rst) begin
      m_pend = 0; m_mask = 0; m_err = 0; m_irq = 0; m_crd = 0;
    end else begin
      m_irq = ((m_pend & m_mask) != 0);
      if (!csr_rd_en)             m_crd = 0;
      else if (csr_addr == 4'h0)  m_crd = m_pend & m_mask;
      else if (csr_addr == 4'h4)  m_crd = {31'd0, m_err};
      else if (csr_addr == 4'h8)  m_crd = m_mask;
      else                        m_crd = 0;
      np = m_pend;
      if (vec_rd_en && int'(vec_rd_idx) < NV) np[vec_rd_idx] = 1'b0;
      if (vec_wr_en && int'(vec_wr_idx) < NV) np[vec_wr_idx] = 1'b1;
      if (vec_wr_en && int'(vec_wr_idx) >= NV) m_err = 1'b1;
      else if (csr_wr_en && csr_addr == 4'h4 && csr_wdata[0]) m_err = 1'b0;
      if (csr_wr_en && csr_addr == 4'h8) m_mask = csr_wdata & VM;
      m_pend = np;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the edge.
  always @(posedge clk) begin
    #1;
    chk("R7 irq_out", {31'd0, irq_out}, {31'd0, m_irq});
    chk("R10 csr_rdata", csr_rdata, m_crd);
    chk("R3 vec_rdata", vec_rdata, 32'd0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic vwrite(int idx);
    @(negedge clk); vec_wr_en = 1; vec_wr_idx = IW'(idx);
    @(negedge clk); vec_wr_en = 0;
  endtask

  task automatic vread(int idx);
    @(negedge clk); vec_rd_en = 1; vec_rd_idx = IW'(idx);
    @(negedge clk); vec_rd_en = 0;
  endtask

  task automatic cwrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk); csr_wr_en = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr_en = 0;
  endtask

  task automatic cread(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); csr_rd_en = 1; csr_addr = a;
    @(negedge clk); d = csr_rdata; csr_rd_en = 0;
  endtask

  initial begin
    logic [31:0] d;
    idle(3);
    rst = 0;
    // R1 reset state
    cread(4'h0, d); chk("R1 status", d, 0);
    cread(4'h4, d); chk("R1 error", d, 0);
    cread(4'h8, d); chk("R1 mask", d, 0);
    chk("R1 irq", {31'd0, irq_out}, 0);

    // R8 masked vector is latched but silent
    vwrite(3); idle(1);
    chk("R8 irq masked", {31'd0, irq_out}, 0);
    cwrite(4'h8, 32'h8); idle(1);
    chk("R5 irq enabled", {31'd0, irq_out}, 1);
    cread(4'h0, d); chk("R6 status one", d, 32'h8);

    // R2 several vectors, R5 mask range
    vwrite(0); vwrite(23);
    cwrite(4'h8, 32'hFFFF_FFFF);
    cread(4'h8, d); chk("R5 mask readback", d, VM);
    cread(4'h0, d); chk("R2 status", d, 32'h0080_0009);

    // R3 acknowledge reads, R7 level held
    vread(3);
    cread(4'h0, d); chk("R3 status after ack", d, 32'h0080_0001);
    chk("R7 irq still high", {31'd0, irq_out}, 1);
    vread(0); vread(23); idle(1);
    chk("R7 irq dropped", {31'd0, irq_out}, 0);
    cread(4'h0, d); chk("R3 status empty", d, 0);

    // R4 same-cycle write and acknowledge
    @(negedge clk); vec_wr_en = 1; vec_wr_idx = 5; vec_rd_en = 1; vec_rd_idx = 5;
    @(negedge clk); vec_wr_en = 0; vec_rd_en = 0;
    cread(4'h0, d); chk("R4 write wins", d, 32'h20);

    // R11 mask cleared, R8 pending kept
    cwrite(4'h8, 32'h0); idle(1);
    chk("R11 irq off", {31'd0, irq_out}, 0);
    cread(4'h0, d); chk("R11 status off", d, 0);
    cwrite(4'h8, 32'h20); idle(1);
    chk("R8 irq restored", {31'd0, irq_out}, 1);
    cread(4'h0, d); chk("R8 status restored", d, 32'h20);
    vread(5);

    // R9 out-of-range write and error register
    cwrite(4'h8, 32'hFFFF_FFFF);
    vwrite(30);
    cread(4'h4, d); chk("R9 error set", d, 1);
    cread(4'h0, d); chk("R9 no pending", d, 0);
    cwrite(4'h4, 32'h0);
    cread(4'h4, d); chk("R9 write zero keeps", d, 1);
    cwrite(4'h4, 32'h1);
    cread(4'h4, d); chk("R9 cleared", d, 0);
    @(negedge clk); vec_wr_en = 1; vec_wr_idx = 40;
    csr_wr_en = 1; csr_addr = 4'h4; csr_wdata = 1;
    @(negedge clk); vec_wr_en = 0; csr_wr_en = 0;
    cread(4'h4, d); chk("R9 set beats clear", d, 1);

    // R10 unmapped offsets
    cread(4'hC, d); chk("R10 offset C", d, 0);
    cread(4'h1, d); chk("R10 offset 1", d, 0);

    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule